// File: doc/BRIEF.md
# Eight-Core Cascaded Result Combiner

This block joins the result and flag registers of eight decision-diagram evaluator cores into one pair of shared cluster registers. Each core has a routing stage. The stages form a chain from core 0 to core 7. At every stage the configured operation is applied to the running value and that core's register. The operation is a bitwise AND or a bitwise OR, or the stage forces the running value to all-zeros or all-ones. The value at the end of the chain is captured into the common registers. Those registers drive the input of core 0 and are visible to every core, so one core's result reaches all the others within one clock.

Each core instruction takes two clocks. The block keeps its own phase bit, and the common registers load only at the edge that closes the second clock of a period. Every core drives an active bit. When a core is idle, its operand is replaced by the neutral constant of its stage's operation: all-ones under AND, all-zeros under OR. An idle core therefore leaves the running value unchanged. A registered done output goes high once all eight cores report that they have finished, which lets a system controller see when the whole cluster has completed.

Stage modes for the result chain and the flag chain are set independently through a single-cycle write port.

Top module: `cascade_cluster`

## Requirements
- R1: While reset is low, and on the first clock after it is released, common_data, common_flag, phase and cluster_done are 0. Reset sets every stage of both chains to OR mode.
- R2: phase inverts on every clock edge. common_data and common_flag load the chain result only at an edge where phase was 1. At all other edges they hold their value.
- R3: Mode code 00 (AND) sets the running value to the running value AND the stage operand. When stage 0 uses AND, its chain starts from all-ones.
- R4: Mode code 01 (OR) sets the running value to the running value OR the stage operand. When stage 0 uses OR, its chain starts from all-zeros.
- R5: Mode code 10 forces the running value to all-zeros, and mode code 11 forces it to all-ones. In both cases the core's register and the earlier stages have no effect.
- R6: When core_active[i] is 0, stage i replaces core i's register with all-ones under AND or all-zeros under OR. The running value then passes through unchanged.
- R7: A write with cfg_we=1 sets the mode of stage cfg_idx in the chain chosen by cfg_lane (0 = result chain, 1 = flag chain). The new mode takes effect from the next edge. No other stage changes.
- R8: The flag chain uses its own stage modes, independent of the result chain, and operates on core_flag.
- R9: cluster_done equals the AND of all core_finish bits sampled at the previous edge.
- R10: The chain is evaluated in order from core 0 (least significant slice of the packed inputs) to core 7, so a later stage acts on what the earlier stages produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_data | input | N_CORES*DATA_W | Result registers of the cores, with core i at bits [i*DATA_W +: DATA_W] |
| core_flag | input | N_CORES*FLAG_W | Flag registers of the cores, with core i at bits [i*FLAG_W +: FLAG_W] |
| core_active | input | N_CORES | Per-core active bit |
| core_finish | input | N_CORES | Per-core finish flag |
| cfg_we | input | 1 | Stage mode write strobe |
| cfg_lane | input | 1 | Chain select for the write: 0 = result chain, 1 = flag chain |
| cfg_idx | input | $clog2(N_CORES) | Stage index for the write |
| cfg_mode | input | 2 | Mode code: 00 AND, 01 OR, 10 zeros, 11 ones |
| common_data | output | DATA_W | Shared result register, also the input of core 0 |
| common_flag | output | FLAG_W | Shared flag register |
| phase | output | 1 | High during the second clock of an instruction period |
| cluster_done | output | 1 | All cores finished, registered |

## Verification
The hardest situation to reach is a chain that mixes AND, OR and forcing stages together with idle cores. In that case an error in the ordering, or in the choice of neutral constant, changes only a few bits. A reference model in the bench walks the chain stage by stage on every clock. The stimulus first sets up the chain on purpose: forcing stages in the middle of AND chains, sparse active masks, and separate flag-chain modes. It then applies a long run of random configuration writes mixed with random operands and masks, so that these mixtures appear in both phases of the instruction period.

// File: rtl/ccl_pkg.sv
package ccl_pkg;

    typedef enum logic [1:0] {
        BOX_AND  = 2'b00,
        BOX_OR   = 2'b01,
        BOX_ZERO = 2'b10,
        BOX_ONE  = 2'b11
    } box_mode_e;

    localparam logic LANE_DATA = 1'b0;
    localparam logic LANE_FLAG = 1'b1;

endpackage

// File: rtl/ccl_route_box.sv
module ccl_route_box
    import ccl_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] operand,
    input  logic         active,
    input  box_mode_e    mode,
    output logic [W-1:0] acc_out
);

    logic [W-1:0] neutral;
    logic [W-1:0] eff_op;

    always_comb begin
        neutral = (mode == BOX_AND) ? {W{1'b1}} : {W{1'b0}};
        eff_op  = active ? operand : neutral;
        unique case (mode)
            BOX_AND:  acc_out = acc_in & eff_op;
            BOX_OR:   acc_out = acc_in | eff_op;
            BOX_ZERO: acc_out = {W{1'b0}};
            default:  acc_out = {W{1'b1}};
        endcase
    end

endmodule

// File: rtl/ccl_lane.sv
module ccl_lane
    import ccl_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic [N*W-1:0] values,
    input  logic [N-1:0]   active,
    input  logic [2*N-1:0] modes,
    output logic [W-1:0]   result
);

    logic [W-1:0] chain [N+1];
    box_mode_e    first_mode;

    assign first_mode = box_mode_e'(modes[1:0]);
    assign chain[0]   = (first_mode == BOX_AND) ? {W{1'b1}} : {W{1'b0}};

    for (genvar i = 0; i < N; i++) begin : g_stage
        ccl_route_box #(.W(W)) i_box (
            .acc_in  (chain[i]),
            .operand (values[i*W +: W]),
            .active  (active[i]),
            .mode    (box_mode_e'(modes[2*i +: 2])),
            .acc_out (chain[i+1])
        );
    end

    assign result = chain[N];

endmodule

// File: rtl/cascade_cluster.sv
module cascade_cluster
    import ccl_pkg::*;
#(
    parameter int N_CORES = 8,
    parameter int DATA_W  = 16,
    parameter int FLAG_W  = 4,
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CORES*DATA_W-1:0] core_data,
    input  logic [N_CORES*FLAG_W-1:0] core_flag,
    input  logic [N_CORES-1:0]        core_active,
    input  logic [N_CORES-1:0]        core_finish,
    input  logic                      cfg_we,
    input  logic                      cfg_lane,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [1:0]                cfg_mode,
    output logic [DATA_W-1:0]         common_data,
    output logic [FLAG_W-1:0]         common_flag,
    output logic                      phase,
    output logic                      cluster_done
);

    typedef struct packed {
        logic                    phase;
        logic                    done;
        logic [DATA_W-1:0]       cdata;
        logic [FLAG_W-1:0]       cflag;
        logic [2*N_CORES-1:0]    dmode;
        logic [2*N_CORES-1:0]    fmode;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] data_res;
    logic [FLAG_W-1:0] flag_res;

    ccl_lane #(.N(N_CORES), .W(DATA_W)) i_data_lane (
        .values (core_data),
        .active (core_active),
        .modes  (st_q.dmode),
        .result (data_res)
    );

    ccl_lane #(.N(N_CORES), .W(FLAG_W)) i_flag_lane (
        .values (core_flag),
        .active (core_active),
        .modes  (st_q.fmode),
        .result (flag_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        st_d.done  = &core_finish;
        if (st_q.phase) begin
            st_d.cdata = data_res;
            st_d.cflag = flag_res;
        end
        if (cfg_we && (int'(cfg_idx) < N_CORES)) begin
            if (cfg_lane == LANE_FLAG) begin
                st_d.fmode[2*cfg_idx +: 2] = cfg_mode;
            end else begin
                st_d.dmode[2*cfg_idx +: 2] = cfg_mode;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < N_CORES; i++) begin
                st_q.dmode[2*i +: 2] <= BOX_OR;
                st_q.fmode[2*i +: 2] <= BOX_OR;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign common_data  = st_q.cdata;
    assign common_flag  = st_q.cflag;
    assign phase        = st_q.phase;
    assign cluster_done = st_q.done;

endmodule

// File: rtl/ccl_checker.sv
module ccl_checker #(
    parameter int N_CORES = 8,
    parameter int DATA_W  = 16,
    parameter int FLAG_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CORES-1:0] core_finish,
    input logic [DATA_W-1:0]  common_data,
    input logic [FLAG_W-1:0]  common_flag,
    input logic               phase,
    input logic               cluster_done
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (common_data == '0 && common_flag == '0 && !cluster_done && !phase));

    p_phase_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase != $past(phase)));

    p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> $stable(common_data));

    p_hold_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> $stable(common_flag));

    p_done_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&core_finish) |=> cluster_done);

    p_done_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(&core_finish) |=> !cluster_done);

endmodule

bind cascade_cluster ccl_checker #(
    .N_CORES (N_CORES),
    .DATA_W  (DATA_W),
    .FLAG_W  (FLAG_W)
) i_ccl_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_finish  (core_finish),
    .common_data  (common_data),
    .common_flag  (common_flag),
    .phase        (phase),
    .cluster_done (cluster_done)
);

// File: tb/test_cascade_cluster.sv
module test_cascade_cluster;

    localparam int CLK_P = 10;
    localparam int N  = 8;
    localparam int DW = 16;
    localparam int FW = 4;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [N*DW-1:0] core_data = '0;
    logic [N*FW-1:0] core_flag = '0;
    logic [N-1:0]    core_active = '0;
    logic [N-1:0]    core_finish = '0;
    logic            cfg_we = 0;
    logic            cfg_lane = 0;
    logic [2:0]      cfg_idx = '0;
    logic [1:0]      cfg_mode = '0;
    logic [DW-1:0]   common_data;
    logic [FW-1:0]   common_flag;
    logic            phase;
    logic            cluster_done;

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    int          m_dmode [N];
    int          m_fmode [N];
    logic [15:0] m_cdata;
    logic [15:0] m_cflag;
    logic        m_phase;
    logic        m_done;

    cascade_cluster #(.N_CORES(N), .DATA_W(DW), .FLAG_W(FW)) i_cascade_cluster (
        .clk, .rst_n, .core_data, .core_flag, .core_active, .core_finish,
        .cfg_we, .cfg_lane, .cfg_idx, .cfg_mode,
        .common_data, .common_flag, .phase, .cluster_done
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // walk the chain stage by stage; vals hold one 16-bit slot per core
    function automatic logic [15:0] walk(input logic [16*N-1:0] vals,
                                         input int md [N],
                                         input logic [N-1:0] act,
                                         input logic [15:0] ones);
        logic [15:0] acc;
        acc = (md[0] == 0) ? ones : 16'h0;
        for (int i = 0; i < N; i++) begin
            logic [15:0] op;
            op = vals[16*i +: 16] & ones;
            case (md[i])
                0: acc = acc & (act[i] ? op : ones);
                1: acc = acc | (act[i] ? op : 16'h0);
                2: acc = 16'h0;
                default: acc = ones;
            endcase
        end
        return acc;
    endfunction

    task automatic compare(string tag);
        check(tag, "common_data", 32'(common_data), 32'(m_cdata));
        check(tag, "common_flag", 32'(common_flag), 32'(m_cflag[FW-1:0]));
        check(tag, "phase", 32'(phase), 32'(m_phase));
        check(tag, "cluster_done", 32'(cluster_done), 32'(m_done));
    endtask

    // inputs are already driven; advance one clock and compare
    task automatic cycle(string tag);
        logic [16*N-1:0] dv, fv;
        for (int i = 0; i < N; i++) begin
            dv[16*i +: 16] = core_data[DW*i +: DW];
            fv[16*i +: 16] = 16'(core_flag[FW*i +: FW]);
        end
        if (m_phase) begin
            m_cdata = walk(dv, m_dmode, core_active, 16'hFFFF);
            m_cflag = walk(fv, m_fmode, core_active, 16'h000F);
        end
        m_done = &core_finish;
        if (cfg_we) begin
            if (cfg_lane) m_fmode[cfg_idx] = int'(cfg_mode);
            else          m_dmode[cfg_idx] = int'(cfg_mode);
        end
        m_phase = !m_phase;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic rand_ops();
        core_data = {$urandom, $urandom, $urandom, $urandom};
        core_flag = $urandom;
    endtask

    task automatic write_mode(string tag, logic lane, int idx, int mode);
        cfg_we = 1; cfg_lane = lane; cfg_idx = 3'(idx); cfg_mode = 2'(mode);
        cycle(tag);
        cfg_we = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog run did not end actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_dmode[i] = 1; m_fmode[i] = 1; end
        m_cdata = 0; m_cflag = 0; m_phase = 0; m_done = 0;
        core_finish = '1;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1;
        core_active = '1;
        rand_ops();
        cycle("R1");
        repeat (4) begin rand_ops(); cycle("R1"); end

        // R4: default OR on every stage
        repeat (12) begin rand_ops(); core_finish = 8'($urandom); cycle("R4"); end

        // R7: switch all result stages to AND
        for (int i = 0; i < N; i++) write_mode("R7", 0, i, 0);

        // R3: dense operands so AND results are non-trivial
        repeat (12) begin
            core_data = {$urandom | $urandom | $urandom, $urandom | $urandom | $urandom,
                         $urandom | $urandom | $urandom, $urandom | $urandom | $urandom};
            cycle("R3");
        end

        // R6: idle cores under AND and then under OR
        repeat (12) begin
            core_data = {$urandom | $urandom, $urandom | $urandom,
                         $urandom | $urandom, $urandom | $urandom};
            core_active = 8'($urandom);
            cycle("R6");
        end
        for (int i = 0; i < N; i++) write_mode("R7", 0, i, 1);
        repeat (12) begin rand_ops(); core_active = 8'($urandom) & 8'($urandom); cycle("R6"); end
        core_active = 8'h00;
        repeat (4) begin rand_ops(); cycle("R6"); end
        core_active = '1;

        // R5 / R10: forcing stage in the middle of an AND chain
        for (int i = 0; i < N; i++) write_mode("R7", 0, i, 0);
        write_mode("R5", 0, 4, 3);
        repeat (6) begin rand_ops(); cycle("R5"); end
        write_mode("R5", 0, 6, 2);
        repeat (4) begin rand_ops(); cycle("R5"); end
        write_mode("R10", 0, 6, 1);
        repeat (6) begin rand_ops(); cycle("R10"); end
        write_mode("R10", 0, 7, 3);
        repeat (4) begin rand_ops(); cycle("R10"); end

        // R8: flag chain with its own modes, result chain held
        write_mode("R8", 1, 0, 0);
        write_mode("R8", 1, 2, 0);
        write_mode("R8", 1, 5, 3);
        write_mode("R8", 1, 6, 0);
        repeat (10) begin core_flag = $urandom; core_active = 8'($urandom); cycle("R8"); end
        core_active = '1;

        // R9: finish patterns
        core_finish = '1;        cycle("R9"); cycle("R9");
        core_finish = 8'h7F;     cycle("R9");
        core_finish = 8'hFE;     cycle("R9");
        core_finish = '1;        cycle("R9");
        core_finish = '0;        cycle("R9");

        // R2: operands change every cycle, updates only at phase-1 edges
        repeat (10) begin rand_ops(); cycle("R2"); end

        // random mix of writes, modes, masks
        repeat (300) begin
            rand_ops();
            core_active = 8'($urandom | $urandom);
            core_finish = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
            if ($urandom % 3 == 0) begin
                cfg_we = 1; cfg_lane = 1'($urandom); cfg_idx = 3'($urandom);
                cfg_mode = 2'($urandom);
            end
            cycle("R7");
            cfg_we = 0;
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule